// File: doc/BRIEF.md
# Bit-Serial Block EEPROM Engine

This block is the device side of a serial EEPROM that carries data over a single data line. The host clocks one bit into the engine with one strobe and pulls one bit out with a second, separate strobe. Each transaction starts with a two-bit command and a six-bit block number. A write then receives a 64-bit frame and a trailing stop bit. A read takes one stop bit, returns four zero bits as a preamble, and then streams the block. The engine keeps 512 bytes internally, arranged as 64 blocks of 8 bytes, so a block number selects the byte address block × 8.

A host drives command, address and write data through the bit-in strobe. After a read command and its stop bit, it switches to the bit-out strobe. The host can watch the data-available flag to know when the returned bits carry block contents.

Top module: `serial_eeprom_engine`

## Requirements
- R1: A synchronous active-high reset puts the engine in its command-waiting state with the data-available flag low, and a bit-out strobe then returns 0.
- R2: The first two bits received form a command, first bit in the upper position. 2'b11 starts a read and 2'b10 starts a write. Codes 2'b00 and 2'b01 are discarded, and the next two bits are decoded as a fresh command.
- R3: All received fields arrive most significant bit first. After the command, exactly six bits give a block number N (0 to 63), which addresses bytes 8N to 8N+7.
- R4: In a read, exactly one stop bit follows the block number. Its value is ignored, and it moves the engine to the preamble.
- R5: The first four bit-out strobes of a read each return 0 while the data-available flag stays low.
- R6: After the preamble, the bit-out strobes return the block as a 64-bit word, most significant bit first. Byte 8N is the top byte and byte 8N+7 the bottom byte. Strobes 1 to 63 return word bits 63 down to 1.
- R7: The 64th data strobe of a read returns 0 and moves the engine back to command-waiting. The data-available flag is low from the next cycle on.
- R8: In a write, 64 data bits follow the block number directly. The first byte received is stored at 8N and the last byte received at 8N+7.
- R9: A write ends with one stop bit. Its value is not stored, and it returns the engine to command-waiting.
- R10: The data-available flag is high exactly while the engine streams read data, and never during the preamble.
- R11: A bit-out strobe outside the preamble and read-data phases returns 0 and does not disturb the transaction in progress.
- R12: A bit-in strobe during the preamble or read-data phase is ignored and does not change the returned stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_in_stb | input | 1 | Consumes `bit_in` at this clock edge |
| bit_in | input | 1 | Serial data bit from the host |
| bit_out_stb | input | 1 | Requests one bit; the shift happens at this clock edge |
| bit_out | output | 1 | Bit returned for the current `bit_out_stb` (valid while it is high) |
| data_avail | output | 1 | High while read data is being streamed |

## Verification
The bench writes blocks 0, 63, 1 and 2, then reads them back bit for bit. This catches a wrong block scaling, which would alias neighbouring blocks, and a reversed byte order, which would swap the ends of the word. It feeds discarded command codes ahead of a valid read, so an engine that accepted them would lose alignment and return shifted data. It puts stop bits of value 1 on both reads and writes, and strobes the "wrong" direction mid-transaction. A design that sampled the stop bit, or reacted to stray strobes, would corrupt the stream or get out of step. It also checks the zero preamble, the zero on the final data strobe and the fall of the data-available flag, so an off-by-one in either counter shows up as a misplaced bit.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;

  localparam int CMD_W = 2;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_BLK,
    ST_RD_STOP,
    ST_PREAMBLE,
    ST_TX_DATA,
    ST_RX_DATA,
    ST_WR_STOP
  } eng_state_t;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_READ,
    OP_WRITE
  } eng_op_t;

  // Command decode: 11 = read, 10 = write, anything else discarded.
  function automatic eng_op_t decode_cmd(input logic [CMD_W-1:0] code);
    case (code)
      2'b11:   return OP_READ;
      2'b10:   return OP_WRITE;
      default: return OP_NONE;
    endcase
  endfunction

  // States in which the bit-out strobe is consumed.
  function automatic logic is_tx_state(input eng_state_t s);
    return (s == ST_PREAMBLE) || (s == ST_TX_DATA);
  endfunction

  // Next value of an MSB-first shift register taking a new bit at the bottom.
  function automatic logic [63:0] shift_in_msb_first(input logic [63:0] cur, input logic b);
    return {cur[62:0], b};
  endfunction

endpackage

// File: rtl/seeprom_rx_shift.sv
module seeprom_rx_shift #(
  parameter int W    = 64,
  parameter int CW   = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift_en,
  input  logic          din,
  input  logic          clear,
  output logic [W-1:0]  data,
  output logic [CW-1:0] cnt,
  output logic [W-1:0]  data_next,
  output logic [CW-1:0] cnt_next
);

  assign data_next = {data[W-2:0], din};
  assign cnt_next  = cnt + CW'(1);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      data <= '0;
      cnt  <= '0;
    end else if (shift_en) begin
      data <= data_next;
      cnt  <= cnt_next;
    end
  end

  // R8: the receive count never passes one full frame
  assert_rx_cnt_bound_R8: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(W));

endmodule

// File: rtl/seeprom_tx_shift.sv
module seeprom_tx_shift #(
  parameter int W  = 64,
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          load,
  input  logic [W-1:0]  load_val,
  input  logic          clear,
  output logic          msb,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_next
);

  logic [W-1:0] data;

  assign msb      = data[W-1];
  assign cnt_next = cnt + CW'(1);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      data <= '0;
      cnt  <= '0;
    end else if (load) begin
      data <= load_val;
      cnt  <= '0;
    end else if (step) begin
      data <= {data[W-2:0], 1'b0};
      cnt  <= cnt_next;
    end
  end

  // R7: the transmit count never passes one full frame
  assert_tx_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(W));

endmodule

// File: rtl/seeprom_block_store.sv
module seeprom_block_store #(
  parameter int BLOCKS = 64,
  parameter int W      = 64,
  parameter int AW     = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  // One word per block: top byte = lowest byte address of the block.
  logic [W-1:0] mem [BLOCKS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/serial_eeprom_engine.sv
module serial_eeprom_engine
  import seeprom_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int BLOCK_BYTES = 8,
  parameter int PRE_BITS    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_in_stb,
  input  logic bit_in,
  input  logic bit_out_stb,
  output logic bit_out,
  output logic data_avail
);

  localparam int DATA_W = BLOCK_BYTES * 8;
  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam int BLOCKS = 1 << ADDR_W;

  eng_state_t state, state_nxt;
  eng_op_t    op_q, op_nxt;
  logic [ADDR_W-1:0] blk_q, blk_nxt;

  logic [DATA_W-1:0] rx_data, rx_next;
  logic [CNT_W-1:0]  rx_cnt, rx_cnt_next;
  logic [CNT_W-1:0]  tx_cnt, tx_cnt_next;
  logic [DATA_W-1:0] rd_word;
  logic              tx_msb;

  logic rx_clear, tx_clear, tx_load, tx_step, mem_we;

  // Named events for checking
  logic in_ev, out_ev, tx_phase;
  logic cmd_done, blk_done, wr_commit, rd_load, rd_finish;

  assign tx_phase = is_tx_state(state);
  assign in_ev    = bit_in_stb && !tx_phase;
  assign out_ev   = bit_out_stb && tx_phase;

  assign cmd_done  = in_ev  && (state == ST_CMD)      && (rx_cnt_next == CNT_W'(CMD_W));
  assign blk_done  = in_ev  && (state == ST_BLK)      && (rx_cnt_next == CNT_W'(ADDR_W));
  assign wr_commit = in_ev  && (state == ST_RX_DATA)  && (rx_cnt_next == CNT_W'(DATA_W));
  assign rd_load   = out_ev && (state == ST_PREAMBLE) && (tx_cnt_next == CNT_W'(PRE_BITS));
  assign rd_finish = out_ev && (state == ST_TX_DATA)  && (tx_cnt_next == CNT_W'(DATA_W));

  seeprom_rx_shift #(.W(DATA_W), .CW(CNT_W)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .shift_en  (in_ev),
    .din       (bit_in),
    .clear     (rx_clear),
    .data      (rx_data),
    .cnt       (rx_cnt),
    .data_next (rx_next),
    .cnt_next  (rx_cnt_next)
  );

  seeprom_tx_shift #(.W(DATA_W), .CW(CNT_W)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .step     (tx_step),
    .load     (tx_load),
    .load_val (rd_word),
    .clear    (tx_clear),
    .msb      (tx_msb),
    .cnt      (tx_cnt),
    .cnt_next (tx_cnt_next)
  );

  seeprom_block_store #(.BLOCKS(BLOCKS), .W(DATA_W), .AW(ADDR_W)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .waddr (blk_q),
    .wdata (rx_next),
    .raddr (blk_q),
    .rdata (rd_word)
  );

  always_comb begin
    state_nxt = state;
    op_nxt    = op_q;
    blk_nxt   = blk_q;
    rx_clear  = 1'b0;
    tx_clear  = 1'b0;
    tx_load   = 1'b0;
    tx_step   = 1'b0;
    mem_we    = 1'b0;
    unique case (state)
      ST_CMD: if (cmd_done) begin
        rx_clear = 1'b1;
        op_nxt   = decode_cmd(rx_next[CMD_W-1:0]);
        if (decode_cmd(rx_next[CMD_W-1:0]) != OP_NONE) state_nxt = ST_BLK;
      end
      ST_BLK: if (blk_done) begin
        rx_clear  = 1'b1;
        blk_nxt   = rx_next[ADDR_W-1:0];
        state_nxt = (op_q == OP_READ) ? ST_RD_STOP : ST_RX_DATA;
      end
      ST_RD_STOP: if (in_ev) begin
        rx_clear  = 1'b1;
        tx_clear  = 1'b1;
        state_nxt = ST_PREAMBLE;
      end
      ST_PREAMBLE: if (out_ev) begin
        tx_step = 1'b1;
        if (rd_load) begin
          tx_load   = 1'b1;
          state_nxt = ST_TX_DATA;
        end
      end
      ST_TX_DATA: if (out_ev) begin
        if (rd_finish) begin
          tx_clear  = 1'b1;
          rx_clear  = 1'b1;
          state_nxt = ST_CMD;
        end else begin
          tx_step = 1'b1;
        end
      end
      ST_RX_DATA: if (wr_commit) begin
        mem_we    = 1'b1;
        rx_clear  = 1'b1;
        state_nxt = ST_WR_STOP;
      end
      ST_WR_STOP: if (in_ev) begin
        rx_clear  = 1'b1;
        tx_clear  = 1'b1;
        state_nxt = ST_CMD;
      end
      default: state_nxt = ST_CMD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_CMD;
      op_q  <= OP_NONE;
      blk_q <= '0;
    end else begin
      state <= state_nxt;
      op_q  <= op_nxt;
      blk_q <= blk_nxt;
    end
  end

  assign data_avail = (state == ST_TX_DATA);
  assign bit_out    = out_ev && (state == ST_TX_DATA) && !rd_finish && tx_msb;

  // R2: a discarded command leaves the engine waiting with an empty receiver
  assert_bad_cmd_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_done && decode_cmd(rx_next[CMD_W-1:0]) == OP_NONE) |=> (state == ST_CMD && rx_cnt == '0));

  // R3: the block field never collects more than its width
  assert_blk_cnt_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BLK) |-> (rx_cnt < CNT_W'(ADDR_W)));

  // R5: the preamble counter stays below its length
  assert_pre_len_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PREAMBLE) |-> (tx_cnt < CNT_W'(PRE_BITS)));

  // R7: final data strobe returns 0 and leaves the read phase
  assert_last_zero_R7: assert property (@(posedge clk) disable iff (rst)
    rd_finish |-> !bit_out);
  assert_rd_return_R7: assert property (@(posedge clk) disable iff (rst)
    rd_finish |=> (state == ST_CMD && !data_avail));

  // R9: a committed write waits for its stop bit
  assert_wr_stop_R9: assert property (@(posedge clk) disable iff (rst)
    wr_commit |=> (state == ST_WR_STOP));

  // R10: the flag only rises out of the preamble
  assert_avail_entry_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(data_avail) |-> ($past(state) == ST_PREAMBLE && tx_cnt == '0));

  // R11: bit-out outside the transmit phases returns 0
  assert_idle_out_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (bit_out_stb && !tx_phase) |-> !bit_out);

  // R12: receiver stays empty while transmitting
  assert_in_ignored_R12: assert property (@(posedge clk) disable iff (rst)
    tx_phase |-> (rx_cnt == '0));

endmodule

// File: tb/serial_eeprom_engine_bench.sv
module serial_eeprom_engine_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_in_stb = 1'b0;
  logic bit_in = 1'b0;
  logic bit_out_stb = 1'b0;
  logic bit_out;
  logic data_avail;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] mdl [512];

  localparam int NV = 4;
  localparam logic [5:0]  VB [NV] = '{6'd0, 6'd63, 6'd1, 6'd2};
  localparam logic [63:0] VD [NV] = '{64'h0123_4567_89AB_CDEF,
                                      64'hF00D_CAFE_8000_0001,
                                      64'hAAAA_5555_FFFF_0000,
                                      64'h8C3E_71D2_0F96_B44B};

  always #4 clk = ~clk;

  serial_eeprom_engine u_serial_eeprom_engine (
    .clk         (clk),
    .rst         (rst),
    .bit_in_stb  (bit_in_stb),
    .bit_in      (bit_in),
    .bit_out_stb (bit_out_stb),
    .bit_out     (bit_out),
    .data_avail  (data_avail)
  );

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic v);
    bit_in = v;
    bit_in_stb = 1'b1;
    @(posedge clk); #1;
    bit_in_stb = 1'b0;
  endtask

  task automatic get_bit(output logic b, output logic a);
    bit_out_stb = 1'b1;
    #2;
    b = bit_out;
    a = data_avail;
    @(posedge clk); #1;
    bit_out_stb = 1'b0;
  endtask

  task automatic send_blk(input logic [5:0] blk);
    for (int i = 5; i >= 0; i--) send_bit(blk[i]);
  endtask

  task automatic write_blk(input logic [5:0] blk, input logic [63:0] w, input logic stop_v);
    send_bit(1'b1); send_bit(1'b0);
    send_blk(blk);
    for (int i = 63; i >= 0; i--) send_bit(w[i]);
    send_bit(stop_v);
    for (int k = 0; k < 8; k++) mdl[int'(blk) * 8 + k] = w[63 - 8*k -: 8];
  endtask

  task automatic read_check(input logic [5:0] blk, input logic stop_v, input logic poke_out,
                            input logic poke_in, input string tag);
    logic [63:0] exp, got;
    logic b, a;
    logic pre_ok, avail_ok;
    pre_ok = 1'b1;
    avail_ok = 1'b1;
    got = '0;
    for (int k = 0; k < 8; k++) exp[63 - 8*k -: 8] = mdl[int'(blk) * 8 + k];
    send_bit(1'b1); send_bit(1'b1);
    for (int i = 5; i >= 0; i--) begin
      send_bit(blk[i]);
      if (poke_out && i == 3) begin
        get_bit(b, a);
        check(b == 1'b0, "R11 stray bit-out during block field", {63'd0, b}, 64'd0);
      end
    end
    send_bit(stop_v);
    for (int d = 0; d < 4; d++) begin
      get_bit(b, a);
      if (b || a) pre_ok = 1'b0;
      if (poke_in && d == 1) send_bit(1'b1);
    end
    check(pre_ok, {"R5 preamble zeros, flag low ", tag}, {63'd0, pre_ok}, 64'd1);
    for (int i = 0; i < 63; i++) begin
      get_bit(b, a);
      got[63 - i] = b;
      if (!a) avail_ok = 1'b0;
      if (poke_in && i == 9) send_bit(1'b0);
    end
    check(got[63:1] == exp[63:1], {"R6 read stream ", tag}, got, exp);
    check(avail_ok, {"R10 flag high during data ", tag}, {63'd0, avail_ok}, 64'd1);
    get_bit(b, a);
    check(b == 1'b0 && a == 1'b1, {"R7 final strobe returns 0 ", tag}, {62'd0, a, b}, 64'd2);
    check(data_avail == 1'b0, {"R7 R10 flag low after read ", tag}, {63'd0, data_avail}, 64'd0);
  endtask

  initial begin : watchdog
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic b, a;
    for (int i = 0; i < 512; i++) mdl[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset state
    check(data_avail == 1'b0, "R1 flag low after reset", {63'd0, data_avail}, 64'd0);
    get_bit(b, a);
    check(b == 1'b0, "R1 R11 bit-out in command state", {63'd0, b}, 64'd0);

    // Vector table: write all, then read all (R3, R6, R8)
    for (int v = 0; v < NV; v++) write_blk(VB[v], VD[v], 1'b0);
    for (int v = 0; v < NV; v++) read_check(VB[v], 1'b0, 1'b0, 1'b0, "R3 R8 table");

    // R2: discarded commands ahead of a valid read
    send_bit(1'b0); send_bit(1'b0);
    send_bit(1'b0); send_bit(1'b1);
    read_check(6'd63, 1'b0, 1'b0, 1'b0, "R2 after discarded codes");

    // R4 + R11: read stop bit of 1, stray bit-out strobe in block field
    read_check(6'd1, 1'b1, 1'b1, 1'b0, "R4 stop=1");

    // R9: write with stop bit 1, then read back
    write_blk(6'd2, 64'hDEAD_BEEF_0BAD_F00D, 1'b1);
    read_check(6'd2, 1'b0, 1'b0, 1'b0, "R9 after stop=1");
    read_check(6'd1, 1'b0, 1'b0, 1'b0, "R3 neighbour intact");

    // R12: bit-in strobes during preamble and data
    read_check(6'd0, 1'b0, 1'b0, 1'b1, "R12 stray bit-in");

    // Reset mid-transaction returns to command state (R1)
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    get_bit(b, a);
    check(b == 1'b0 && a == 1'b0, "R1 reset mid-command", {62'd0, a, b}, 64'd0);
    read_check(6'd63, 1'b0, 1'b0, 1'b0, "R1 after mid reset");

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule